// File: doc/BRIEF.md
# Tiled Projection Compression Scheduler

This block sequences a windowed random-projection compression of a pixel image. The image is cut into square windows of `ws` by `ws` pixels, and every pixel is projected by the measurement matrix that belongs to its position inside its window, so only `ws*ws` distinct matrices exist. The loops are reordered so that the outer walk runs over window offsets (u,v) and the inner walk runs over every pixel at that offset. Each matrix is therefore requested from external memory once and then applied to all `(lines/ws)*(samples/ws)` pixels that share it. Within a tile every pixel vector is read `q` times, once for each row of its matrix. Each of these reads gives one element of the compressed pixel.

Matrix and pixel data land in two local stores. Each store is a simple dual-port memory split into two banks that alternate from tile to tile. A fetch unit issues transfer requests, each with a start address, a length and a kind, and it produces the local write addresses as beats arrive. A read walker starts the compute engine and drives the read addresses and the write-back addresses of the compressed elements. The fetch of tile t+1 runs while tile t computes. The engine is restarted only when it has reported done and the next tile is fully resident. Pixels are stored band-interleaved-by-pixel, and all addresses and lengths count beats of `LANES` bands.

Top module: `tcs_top`

## Requirements
- R1: After an accepted start, matrix requests (`req_is_mat_o`=1) are issued for tiles m = u*ws+v in row-major offset order, each exactly once, with address `h_base + m*q*nb` and length `q*nb`, where nb = bands/LANES.
- R2: After its matrix, each tile issues one pixel request (`req_is_mat_o`=0) per pixel (i,j), with i = u, u+ws, … and j = v, v+ws, …, j varying fastest, address `px_base + (i*samples+j)*nb` and length nb. A request holds its address and length until it is accepted.
- R3: Local write addresses carry the bank in the MSB, equal to the parity of the tile index. The low bits count beats from zero within the matrix (H store) or across the tile's whole pixel set (pixel store).
- R4: `eng_start_o` for tile t is raised only after every beat of tile t has been delivered. Requests for the next tile are issued while the engine computes.
- R5: The fetch never writes a bank whose tile has not yet been released by the compute engine's done.
- R6: While computing, reads go pixel by pixel, then matrix row k, then beat b. The H read offset is k*nb+b and the pixel read offset is p*nb+b, where p is the pixel's index in the set. Both carry the tile's bank in the MSB.
- R7: `y_valid_o` pulses once per (pixel,k), on the last beat of that row, with `y_addr_o` = (i*samples+j)*q+k.
- R8: After a start, the engine is not started again until it has pulsed `eng_done_i`.
- R9: `done_o` rises only after the engine's done for the last tile. At that point `busy_o` falls. A new start clears `done_o`.
- R10: A start while busy is ignored. The configuration is captured at the accepted start, and later changes to it have no effect.
- R11: Out of reset, busy, done, request, write, read, start and write-back strobes are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a frame (taken when idle) |
| lines_i | input | LINE_W | Image lines |
| samples_i | input | LINE_W | Image samples per line |
| ws_i | input | WS_W | Window size |
| bands_i | input | BAND_W | Bands per pixel, a multiple of LANES |
| q_i | input | Q_W | Measurements per pixel |
| h_base_i | input | AW | External base of the matrices, in beats |
| px_base_i | input | AW | External base of the image, in beats |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | Frame complete |
| req_valid_o | output | 1 | Transfer request valid |
| req_ready_i | input | 1 | Transfer request accepted |
| req_addr_o | output | AW | Request start address |
| req_len_o | output | LEN_W | Request length in beats |
| req_is_mat_o | output | 1 | 1 = matrix, 0 = pixel |
| in_valid_i | input | 1 | One beat of the current request arrives |
| h_we_o | output | 1 | H store write enable |
| h_wr_addr_o | output | H_OW+1 | H store write address |
| px_we_o | output | 1 | Pixel store write enable |
| px_wr_addr_o | output | P_OW+1 | Pixel store write address |
| eng_start_o | output | 1 | Compute engine start |
| eng_done_i | input | 1 | Compute engine done |
| rd_valid_o | output | 1 | Read addresses valid |
| h_rd_addr_o | output | H_OW+1 | H store read address |
| px_rd_addr_o | output | P_OW+1 | Pixel store read address |
| y_valid_o | output | 1 | Compressed element complete |
| y_addr_o | output | AW | Write-back element address |

## Verification
The assertions assume that the engine pulses done only after the read walk of the tile it was started on has ended. They also assume that beats arrive only after a request has been accepted and never exceed the length that was asked for, and that lines and samples are multiples of the window size. The bench's transfer model accepts one request at a time after a short delay and returns exactly the requested number of beats, with gaps between them. Its engine model answers a start only after the read strobe has dropped and a further delay has passed. Every configuration used divides evenly, so no stimulus leaves these assumptions.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  typedef enum logic [2:0] {
    F_IDLE, F_WAIT, F_MREQ, F_MDAT, F_PREQ, F_PDAT
  } fetch_st_e;

  typedef enum logic [1:0] {
    A_IDLE, A_WAIT, A_RUN, A_DRAIN
  } agen_st_e;
endpackage

// File: rtl/tcs_tile_walk.sv
// Steps through all pixels that share one window offset.
module tcs_tile_walk #(
  parameter int LINE_W = 11,
  parameter int WS_W   = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [WS_W-1:0]   u_i,
  input  logic [WS_W-1:0]   v_i,
  input  logic [WS_W-1:0]   ws_i,
  input  logic [LINE_W-1:0] lines_i,
  input  logic [LINE_W-1:0] samples_i,
  output logic [LINE_W-1:0] row_o,
  output logic [LINE_W-1:0] col_o,
  output logic              last_o
);
  logic [LINE_W-1:0] row_q, col_q, v_q;
  logic [LINE_W:0]   row_nx, col_nx;
  logic              row_end, col_end;

  assign row_nx  = {1'b0, row_q} + {1'b0, LINE_W'(ws_i)};
  assign col_nx  = {1'b0, col_q} + {1'b0, LINE_W'(ws_i)};
  assign row_end = row_nx >= {1'b0, lines_i};
  assign col_end = col_nx >= {1'b0, samples_i};
  assign last_o  = row_end && col_end;
  assign row_o   = row_q;
  assign col_o   = col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      col_q <= '0;
      v_q   <= '0;
    end else if (load_i) begin
      row_q <= LINE_W'(u_i);
      col_q <= LINE_W'(v_i);
      v_q   <= LINE_W'(v_i);
    end else if (step_i) begin
      if (col_end) begin
        col_q <= v_q;
        row_q <= row_nx[LINE_W-1:0];
      end else begin
        col_q <= col_nx[LINE_W-1:0];
      end
    end
  end
endmodule

// File: rtl/tcs_fetch.sv
// Issues matrix and pixel requests per tile, generates local write addresses.
module tcs_fetch
  import tcs_pkg::*;
#(
  parameter int LINE_W = 11,
  parameter int WS_W   = 7,
  parameter int Q_W    = 7,
  parameter int BAND_W = 9,
  parameter int AW     = 32,
  parameter int LEN_W  = 16,
  parameter int H_OW   = 12,
  parameter int P_OW   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [LINE_W-1:0] lines_i,
  input  logic [LINE_W-1:0] samples_i,
  input  logic [WS_W-1:0]   ws_i,
  input  logic [BAND_W-1:0] nbeat_i,
  input  logic [Q_W-1:0]    q_i,
  input  logic [AW-1:0]     h_base_i,
  input  logic [AW-1:0]     px_base_i,
  input  logic [1:0]        bank_free_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [AW-1:0]     req_addr_o,
  output logic [LEN_W-1:0]  req_len_o,
  output logic              req_is_mat_o,
  input  logic              in_valid_i,
  output logic              h_we_o,
  output logic [H_OW:0]     h_wr_addr_o,
  output logic              px_we_o,
  output logic [P_OW:0]     px_wr_addr_o,
  output logic              fill_o,
  output logic              bank_o
);
  localparam int M_W = 2 * WS_W;

  fetch_st_e          st_q;
  logic [WS_W-1:0]    u_q, v_q;
  logic [M_W-1:0]     m_q;
  logic               bank_q;
  logic [H_OW-1:0]    hcnt_q;
  logic [P_OW-1:0]    pcnt_q;
  logic [BAND_W-1:0]  bcnt_q;
  logic [LINE_W-1:0]  row, col;
  logic               walk_last, walk_load, walk_step;
  logic [LEN_W-1:0]   mat_len;
  logic               last_tile, beat_end;

  assign mat_len   = LEN_W'(q_i) * LEN_W'(nbeat_i);
  assign last_tile = (u_q == ws_i - 1'b1) && (v_q == ws_i - 1'b1);
  assign beat_end  = (st_q == F_PDAT) && in_valid_i && (bcnt_q == nbeat_i - 1'b1);
  assign walk_load = (st_q == F_WAIT) && bank_free_i[bank_q];
  assign walk_step = beat_end && !walk_last;
  assign fill_o    = beat_end && walk_last;
  assign bank_o    = bank_q;

  tcs_tile_walk #(.LINE_W(LINE_W), .WS_W(WS_W)) u_walk (
    .clk_i, .rst_ni,
    .load_i(walk_load), .step_i(walk_step),
    .u_i(u_q), .v_i(v_q), .ws_i,
    .lines_i, .samples_i,
    .row_o(row), .col_o(col), .last_o(walk_last)
  );

  always_comb begin
    req_valid_o  = (st_q == F_MREQ) || (st_q == F_PREQ);
    req_is_mat_o = (st_q == F_MREQ);
    if (st_q == F_MREQ) begin
      req_addr_o = h_base_i + AW'(m_q) * AW'(mat_len);
      req_len_o  = mat_len;
    end else begin
      req_addr_o = px_base_i + (AW'(row) * AW'(samples_i) + AW'(col)) * AW'(nbeat_i);
      req_len_o  = LEN_W'(nbeat_i);
    end
    h_we_o       = (st_q == F_MDAT) && in_valid_i;
    px_we_o      = (st_q == F_PDAT) && in_valid_i;
    h_wr_addr_o  = {bank_q, hcnt_q};
    px_wr_addr_o = {bank_q, pcnt_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= F_IDLE;
      u_q    <= '0;
      v_q    <= '0;
      m_q    <= '0;
      bank_q <= 1'b0;
      hcnt_q <= '0;
      pcnt_q <= '0;
      bcnt_q <= '0;
    end else if (go_i) begin
      st_q   <= F_WAIT;
      u_q    <= '0;
      v_q    <= '0;
      m_q    <= '0;
      bank_q <= 1'b0;
    end else begin
      unique case (st_q)
        F_WAIT: if (bank_free_i[bank_q]) st_q <= F_MREQ;
        F_MREQ: if (req_ready_i) begin
          st_q   <= F_MDAT;
          hcnt_q <= '0;
        end
        F_MDAT: if (in_valid_i) begin
          hcnt_q <= hcnt_q + 1'b1;
          if (hcnt_q == H_OW'(mat_len - LEN_W'(1))) begin
            st_q   <= F_PREQ;
            pcnt_q <= '0;
          end
        end
        F_PREQ: if (req_ready_i) begin
          st_q   <= F_PDAT;
          bcnt_q <= '0;
        end
        F_PDAT: if (in_valid_i) begin
          pcnt_q <= pcnt_q + 1'b1;
          bcnt_q <= bcnt_q + 1'b1;
          if (bcnt_q == nbeat_i - 1'b1) begin
            if (walk_last) begin
              m_q <= m_q + 1'b1;
              if (v_q == ws_i - 1'b1) begin
                v_q <= '0;
                u_q <= u_q + 1'b1;
              end else begin
                v_q <= v_q + 1'b1;
              end
              if (last_tile) begin
                st_q <= F_IDLE;
              end else begin
                bank_q <= ~bank_q;
                st_q   <= F_WAIT;
              end
            end else begin
              st_q <= F_PREQ;
            end
          end
        end
        default: ;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i && !go_i |=> req_valid_o && $stable(req_addr_o) && $stable(req_len_o)); // R2
endmodule

// File: rtl/tcs_agen.sv
// Starts the engine per resident tile and walks read / write-back addresses.
module tcs_agen
  import tcs_pkg::*;
#(
  parameter int LINE_W = 11,
  parameter int WS_W   = 7,
  parameter int Q_W    = 7,
  parameter int BAND_W = 9,
  parameter int AW     = 32,
  parameter int H_OW   = 12,
  parameter int P_OW   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [LINE_W-1:0] lines_i,
  input  logic [LINE_W-1:0] samples_i,
  input  logic [WS_W-1:0]   ws_i,
  input  logic [BAND_W-1:0] nbeat_i,
  input  logic [Q_W-1:0]    q_i,
  input  logic [1:0]        loaded_i,
  input  logic              eng_done_i,
  output logic              eng_start_o,
  output logic              bank_o,
  output logic              release_o,
  output logic              all_done_o,
  output logic              rd_valid_o,
  output logic [H_OW:0]     h_rd_addr_o,
  output logic [P_OW:0]     px_rd_addr_o,
  output logic              y_valid_o,
  output logic [AW-1:0]     y_addr_o
);
  agen_st_e           st_q;
  logic [WS_W-1:0]    u_q, v_q;
  logic               bank_q;
  logic [BAND_W-1:0]  b_q;
  logic [Q_W-1:0]     k_q;
  logic [H_OW-1:0]    hoff_q;
  logic [P_OW-1:0]    pbase_q;
  logic [LINE_W-1:0]  row, col;
  logic               walk_last, start_ok, beat_last, k_last, last_tile;

  assign start_ok  = (st_q == A_WAIT) && loaded_i[bank_q];
  assign beat_last = b_q == nbeat_i - 1'b1;
  assign k_last    = k_q == q_i - 1'b1;
  assign last_tile = (u_q == ws_i - 1'b1) && (v_q == ws_i - 1'b1);

  assign eng_start_o  = start_ok;
  assign bank_o       = bank_q;
  assign release_o    = (st_q == A_DRAIN) && eng_done_i;
  assign all_done_o   = release_o && last_tile;
  assign rd_valid_o   = st_q == A_RUN;
  assign h_rd_addr_o  = {bank_q, hoff_q};
  assign px_rd_addr_o = {bank_q, pbase_q + P_OW'(b_q)};
  assign y_valid_o    = rd_valid_o && beat_last;
  assign y_addr_o     = (AW'(row) * AW'(samples_i) + AW'(col)) * AW'(q_i) + AW'(k_q);

  tcs_tile_walk #(.LINE_W(LINE_W), .WS_W(WS_W)) u_walk (
    .clk_i, .rst_ni,
    .load_i(start_ok), .step_i(rd_valid_o && beat_last && k_last && !walk_last),
    .u_i(u_q), .v_i(v_q), .ws_i,
    .lines_i, .samples_i,
    .row_o(row), .col_o(col), .last_o(walk_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= A_IDLE;
      u_q     <= '0;
      v_q     <= '0;
      bank_q  <= 1'b0;
      b_q     <= '0;
      k_q     <= '0;
      hoff_q  <= '0;
      pbase_q <= '0;
    end else if (go_i) begin
      st_q   <= A_WAIT;
      u_q    <= '0;
      v_q    <= '0;
      bank_q <= 1'b0;
    end else begin
      unique case (st_q)
        A_WAIT: if (start_ok) begin
          st_q    <= A_RUN;
          b_q     <= '0;
          k_q     <= '0;
          hoff_q  <= '0;
          pbase_q <= '0;
        end
        A_RUN: begin
          if (beat_last) begin
            b_q <= '0;
            if (k_last) begin
              k_q     <= '0;
              hoff_q  <= '0;
              pbase_q <= pbase_q + P_OW'(nbeat_i);
              if (walk_last) st_q <= A_DRAIN;
            end else begin
              k_q    <= k_q + 1'b1;
              hoff_q <= hoff_q + 1'b1;
            end
          end else begin
            b_q    <= b_q + 1'b1;
            hoff_q <= hoff_q + 1'b1;
          end
        end
        A_DRAIN: if (eng_done_i) begin
          if (v_q == ws_i - 1'b1) begin
            v_q <= '0;
            u_q <= u_q + 1'b1;
          end else begin
            v_q <= v_q + 1'b1;
          end
          if (last_tile) begin
            st_q <= A_IDLE;
          end else begin
            bank_q <= ~bank_q;
            st_q   <= A_WAIT;
          end
        end
        default: ;
      endcase
    end
  end

  AST_DONE_IN_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_done_i |-> st_q == A_DRAIN); // R8
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |=> !eng_start_o until_with release_o); // R8
endmodule

// File: rtl/tcs_top.sv
module tcs_top #(
  parameter int LINE_W       = 11,
  parameter int WS_W         = 7,
  parameter int Q_W          = 7,
  parameter int BAND_W       = 9,
  parameter int LANES        = 4,
  parameter int MAX_Q        = 64,
  parameter int MAX_BANDS    = 256,
  parameter int MAX_TILE_PIX = 1024,
  parameter int AW           = 32,
  parameter int LEN_W        = 16,
  localparam int LOG_LANES   = $clog2(LANES),
  localparam int H_OW        = $clog2(MAX_Q * MAX_BANDS / LANES),
  localparam int P_OW        = $clog2(MAX_TILE_PIX * MAX_BANDS / LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LINE_W-1:0] lines_i,
  input  logic [LINE_W-1:0] samples_i,
  input  logic [WS_W-1:0]   ws_i,
  input  logic [BAND_W-1:0] bands_i,
  input  logic [Q_W-1:0]    q_i,
  input  logic [AW-1:0]     h_base_i,
  input  logic [AW-1:0]     px_base_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [AW-1:0]     req_addr_o,
  output logic [LEN_W-1:0]  req_len_o,
  output logic              req_is_mat_o,
  input  logic              in_valid_i,
  output logic              h_we_o,
  output logic [H_OW:0]     h_wr_addr_o,
  output logic              px_we_o,
  output logic [P_OW:0]     px_wr_addr_o,
  output logic              eng_start_o,
  input  logic              eng_done_i,
  output logic              rd_valid_o,
  output logic [H_OW:0]     h_rd_addr_o,
  output logic [P_OW:0]     px_rd_addr_o,
  output logic              y_valid_o,
  output logic [AW-1:0]     y_addr_o
);
  logic [LINE_W-1:0] lines_q, samples_q;
  logic [WS_W-1:0]   ws_q;
  logic [BAND_W-1:0] bands_q, nbeat;
  logic [Q_W-1:0]    q_q;
  logic [AW-1:0]     h_base_q, px_base_q;
  logic              busy_q, done_q, go;
  logic [1:0]        loaded_q;
  logic              fill, fill_bank, rel, ag_bank, all_done;

  assign go     = start_i && !busy_q;
  assign nbeat  = bands_q >> LOG_LANES;
  assign busy_o = busy_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lines_q   <= '0;
      samples_q <= '0;
      ws_q      <= '0;
      bands_q   <= '0;
      q_q       <= '0;
      h_base_q  <= '0;
      px_base_q <= '0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
    end else if (go) begin
      lines_q   <= lines_i;
      samples_q <= samples_i;
      ws_q      <= ws_i;
      bands_q   <= bands_i;
      q_q       <= q_i;
      h_base_q  <= h_base_i;
      px_base_q <= px_base_i;
      busy_q    <= 1'b1;
      done_q    <= 1'b0;
    end else if (all_done) begin
      busy_q <= 1'b0;
      done_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          loaded_q[g] <= 1'b0;
      else if (go)                          loaded_q[g] <= 1'b0;
      else if (fill && fill_bank == g[0])   loaded_q[g] <= 1'b1;
      else if (rel && ag_bank == g[0])      loaded_q[g] <= 1'b0;
    end
  end

  tcs_fetch #(
    .LINE_W(LINE_W), .WS_W(WS_W), .Q_W(Q_W), .BAND_W(BAND_W),
    .AW(AW), .LEN_W(LEN_W), .H_OW(H_OW), .P_OW(P_OW)
  ) u_fetch (
    .clk_i, .rst_ni, .go_i(go),
    .lines_i(lines_q), .samples_i(samples_q), .ws_i(ws_q),
    .nbeat_i(nbeat), .q_i(q_q),
    .h_base_i(h_base_q), .px_base_i(px_base_q),
    .bank_free_i(~loaded_q),
    .req_valid_o, .req_ready_i, .req_addr_o, .req_len_o, .req_is_mat_o,
    .in_valid_i, .h_we_o, .h_wr_addr_o, .px_we_o, .px_wr_addr_o,
    .fill_o(fill), .bank_o(fill_bank)
  );

  tcs_agen #(
    .LINE_W(LINE_W), .WS_W(WS_W), .Q_W(Q_W), .BAND_W(BAND_W),
    .AW(AW), .H_OW(H_OW), .P_OW(P_OW)
  ) u_agen (
    .clk_i, .rst_ni, .go_i(go),
    .lines_i(lines_q), .samples_i(samples_q), .ws_i(ws_q),
    .nbeat_i(nbeat), .q_i(q_q),
    .loaded_i(loaded_q), .eng_done_i,
    .eng_start_o, .bank_o(ag_bank), .release_o(rel), .all_done_o(all_done),
    .rd_valid_o, .h_rd_addr_o, .px_rd_addr_o, .y_valid_o, .y_addr_o
  );

  AST_START_RESIDENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |-> loaded_q[ag_bank]); // R4
  AST_FILL_FREE_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_we_o || px_we_o |-> !loaded_q[fill_bank]); // R5
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !req_valid_o && !rd_valid_o && loaded_q == 2'b00); // R9
  AST_IGNORE_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && busy_o && !all_done |=> busy_o && $stable(ws_q) && $stable(q_q)); // R10
endmodule

// File: tb/tcs_top_tb_top.sv
module tcs_top_tb_top;
  localparam int LINE_W = 11, WS_W = 7, Q_W = 7, BAND_W = 9, AW = 32, LEN_W = 16;
  localparam int H_OW = 12, P_OW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              start;
  logic [LINE_W-1:0] lines, samples;
  logic [WS_W-1:0]   ws;
  logic [BAND_W-1:0] bands;
  logic [Q_W-1:0]    q;
  logic [AW-1:0]     h_base, px_base;
  logic              busy, done, req_valid, req_ready, req_is_mat, in_valid;
  logic [AW-1:0]     req_addr, y_addr;
  logic [LEN_W-1:0]  req_len;
  logic              h_we, px_we, eng_start, eng_done, rd_valid, y_valid;
  logic [H_OW:0]     h_wr_addr, h_rd_addr;
  logic [P_OW:0]     px_wr_addr, px_rd_addr;

  tcs_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .lines_i(lines), .samples_i(samples), .ws_i(ws), .bands_i(bands), .q_i(q),
    .h_base_i(h_base), .px_base_i(px_base),
    .busy_o(busy), .done_o(done),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_addr_o(req_addr),
    .req_len_o(req_len), .req_is_mat_o(req_is_mat), .in_valid_i(in_valid),
    .h_we_o(h_we), .h_wr_addr_o(h_wr_addr), .px_we_o(px_we), .px_wr_addr_o(px_wr_addr),
    .eng_start_o(eng_start), .eng_done_i(eng_done),
    .rd_valid_o(rd_valid), .h_rd_addr_o(h_rd_addr), .px_rd_addr_o(px_rd_addr),
    .y_valid_o(y_valid), .y_addr_o(y_addr)
  );

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit timed_out = 0;
  // request item: {is_mat, tile_last, len[15:0], addr[31:0]}
  logic [49:0] req_q[$];
  logic [63:0] hw_q[$], pw_q[$], rd_q[$], y_q[$];
  int tiles_filled = 0, tiles_started = 0, eng_dones = 0, overlap = 0;
  bit eng_active = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic pop_cmp(ref logic [63:0] qq[$], input logic [63:0] act, input string tag);
    logic [63:0] e;
    if (qq.size() == 0) begin
      chk(0, tag, act, 64'hdead);
    end else begin
      e = qq.pop_front();
      chk(act == e, tag, act, e);
    end
  endtask

  // Driver: pushes the expected streams for one frame.
  task automatic push_frame(input int L, input int S, input int W, input int B, input int Q,
                            input int hb, input int pb);
    int nb = B / 4;
    for (int u = 0; u < W; u++)
      for (int v = 0; v < W; v++) begin
        int t = u * W + v;
        int bk = t % 2;
        int p = 0;
        req_q.push_back({1'b1, 1'b0, 16'(Q * nb), 32'(hb + t * Q * nb)});
        for (int x = 0; x < Q * nb; x++) hw_q.push_back(64'((bk << H_OW) | x));
        for (int i = u; i < L; i += W)
          for (int j = v; j < S; j += W) begin
            bit tl = (i + W >= L) && (j + W >= S);
            req_q.push_back({1'b0, tl, 16'(nb), 32'(pb + (i * S + j) * nb)});
            for (int x = 0; x < nb; x++) pw_q.push_back(64'((bk << P_OW) | (p * nb + x)));
            for (int k = 0; k < Q; k++)
              for (int x = 0; x < nb; x++) begin
                rd_q.push_back({32'((bk << H_OW) | (k * nb + x)), 32'((bk << P_OW) | (p * nb + x))});
                if (x == nb - 1) y_q.push_back(64'((i * S + j) * Q + k));
              end
            p++;
          end
      end
  endtask

  // Transfer model: accepts one request at a time and delivers its beats.
  initial begin
    req_ready = 0;
    in_valid = 0;
    forever begin
      @(negedge clk);
      if (req_valid) begin
        logic [49:0] e;
        logic [49:0] a;
        a = {req_is_mat, 1'b0, req_len, req_addr};
        if (req_q.size() == 0) begin
          chk(0, "R1/R2 unexpected request", 64'(a), 64'h0);
          e = a;
        end else begin
          e = req_q.pop_front();
          chk({e[49], e[47:0]} == {a[49], a[47:0]}, e[49] ? "R1 matrix request" : "R2 pixel request",
              64'(a), 64'(e));
        end
        @(negedge clk);
        chk(req_valid && req_addr == a[31:0], "R2 request held", 64'(req_addr), 64'(a[31:0]));
        req_ready = 1;
        if (eng_active) overlap++;
        @(negedge clk);
        req_ready = 0;
        for (int n = 0; n < int'(e[47:32]); n++) begin
          if (n % 3 == 1) @(negedge clk);
          in_valid = 1;
          @(negedge clk);
          in_valid = 0;
        end
        if (e[48]) tiles_filled++;
      end
    end
  end

  // Engine model.
  initial begin
    eng_done = 0;
    @(negedge clk);
    forever begin
      #1;
      if (eng_start && rst_n) begin
        chk(!eng_active, "R8 start while engine busy", 64'(eng_active), 64'h0);
        chk(tiles_filled > tiles_started, "R4 start before tile resident",
            64'(tiles_filled), 64'(tiles_started + 1));
        tiles_started++;
        eng_active = 1;
        while (!rd_valid) begin @(negedge clk); #1; end
        while (rd_valid) begin @(negedge clk); #1; end
        repeat (4) @(negedge clk);
        eng_done = 1;
        @(negedge clk);
        eng_done = 0;
        eng_active = 0;
        eng_dones++;
      end else begin
        @(negedge clk);
      end
    end
  end

  // Monitor: compares write, read and write-back streams.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (h_we)     pop_cmp(hw_q, 64'(h_wr_addr), "R3 H write address");
      if (px_we)    pop_cmp(pw_q, 64'(px_wr_addr), "R3/R5 pixel write address");
      if (rd_valid) pop_cmp(rd_q, {32'(h_rd_addr), 32'(px_rd_addr)}, "R6 read addresses");
      if (y_valid)  pop_cmp(y_q, 64'(y_addr), "R7 write-back address");
    end
  end

  // Watchdog.
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !timed_out) begin
      timed_out = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=%0d exp=<150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic run_frame(input int L, input int S, input int W, input int B, input int Q,
                           input int hb, input int pb, input bit poke_busy);
    int t0 = eng_dones;
    int ov0 = overlap;
    push_frame(L, S, W, B, Q, hb, pb);
    @(negedge clk);
    lines = L[LINE_W-1:0]; samples = S[LINE_W-1:0]; ws = W[WS_W-1:0];
    bands = B[BAND_W-1:0]; q = Q[Q_W-1:0]; h_base = hb; px_base = pb;
    start = 1;
    @(negedge clk);
    start = 0;
    // R10: configuration changes after the accepted start must not matter
    lines = 7; samples = 5; ws = 3; q = 5; h_base = 32'h9999; px_base = 32'h7777;
    #1;
    chk(busy && !done, "R9 busy after start, done cleared", {busy, done}, 2'b10);
    if (poke_busy) begin
      while (eng_dones == t0) @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
      #1;
      chk(busy && !done, "R10 start while busy ignored", {busy, done}, 2'b10);
    end
    while (!done && !timed_out) @(negedge clk);
    #1;
    chk(eng_dones - t0 == W * W, "R9 done after last engine done", 64'(eng_dones - t0), 64'(W * W));
    chk(!busy, "R9 busy cleared at done", 64'(busy), 64'h0);
    chk(req_q.size() + hw_q.size() + pw_q.size() + rd_q.size() + y_q.size() == 0,
        "R1/R2/R6/R7 all expected items seen",
        64'(req_q.size() + hw_q.size() + pw_q.size() + rd_q.size() + y_q.size()), 64'h0);
    if (W > 1) chk(overlap > ov0, "R4 prefetch overlaps compute", 64'(overlap - ov0), 64'h1);
    repeat (3) @(negedge clk);
    #1;
    chk(done && !req_valid && !rd_valid, "R9 done holds, quiet",
        {done, req_valid, rd_valid}, 3'b100);
  endtask

  initial begin
    start = 0; lines = 0; samples = 0; ws = 0; bands = 0; q = 0; h_base = 0; px_base = 0;
    repeat (3) @(negedge clk);
    #1;
    // R11 reset state
    chk({busy, done, req_valid, h_we, px_we, eng_start, rd_valid, y_valid} == 8'h0,
        "R11 reset outputs idle",
        {busy, done, req_valid, h_we, px_we, eng_start, rd_valid, y_valid}, 8'h0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    run_frame(4, 4, 2, 8, 2, 32'h1000, 32'h4000, 1);
    run_frame(6, 3, 3, 4, 3, 32'h200, 32'h8000, 0);
    run_frame(2, 3, 1, 8, 1, 32'h0, 32'h100, 0);
    run_frame(4, 2, 2, 16, 4, 32'h50, 32'h2000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule